// File: doc/BRIEF.md
# System Control Register Bank

This block is a bank of 32-bit system control and status registers decoded inside a 4 KiB window. A simple bus accesses it with a write strobe, a read strobe, a byte offset and a 32-bit write data word. Reads return data one cycle after the strobe. Each register follows one of four access policies: plain read/write, read-only, write-one-to-clear or write-one-to-set. The policy is fixed per register and its behaviour depends on the register's location.

On reset, every register loads its start value. Most start values are fixed constants. Two registers capture strap inputs, one holding the boot straps and one holding the disabled-module mask. A memory configuration register captures a code derived from the DRAM size parameter. The DRAM size must be a power of two from 128 MiB to 2048 MiB, and any other value stops elaboration. An access beyond the last implemented register does nothing to the state and raises a one-cycle error flag.

Top module: `sysctl_regbank`

## Requirements
- R1: The register index is `bus_off[11:2]`, and indices 0 to 81 are implemented. A read strobe at clock edge k places the addressed word on `bus_rdata` after edge k. Without a read strobe, `bus_rdata` holds its value.
- R2: A read at an index of 82 or above returns zero.
- R3: A write at an index of 82 or above leaves every register unchanged.
- R4: `range_err` is high for exactly the one cycle after a read or write at an index of 82 or above, and is low otherwise.
- R5: The registers at byte offsets 0x000, 0x004 and 0x040 are read-only, and writes to them have no effect.
- R6: The registers at 0x06C and 0x0D4 clear to write-one: the new value is the old value AND NOT the write data.
- R7: The registers at 0x070 and 0x07C set to write-one: the new value is the old value OR the write data.
- R8: Every other implemented register stores the full written word.
- R9: Reset values are fixed as follows. Registers not listed, and not covered by R10 or R11, reset to 0.

  | Offset | Reset value |
  |---|---|
  | 0x000 | 0x04A92750 |
  | 0x014 | 0x0000FFFF |
  | 0x038 | 0x00000003 |
  | 0x03C | 0x0000035E |
  | 0x050 | 0x0000004E |
  | 0x060 | 0x00080000 |
  | 0x06C | 0x80000000 |
  | 0x078 | 0x000000C0 |
  | 0x098 | 0x5A00F3CF |
  | 0x13C | 0x00000008 |
  | 0x140 | 0x034730E4 |
  | 0x144 | 0x034730E4 |

- R10: On reset, 0x004 loads `strap_boot` and 0x07C loads `strap_mod_off`.
- R11: On reset, 0x09C loads 0x00001002 OR (log2(DRAM_MB/128) << 8).
- R12: When a read and a write address the same register in one cycle, the read returns the value from before the write.
- R13: Reset is synchronous and active-low. While reset is applied, `bus_rdata` and `range_err` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_off | input | 12 | Byte offset inside the window |
| bus_wdata | input | 32 | Write data |
| strap_boot | input | 32 | Boot strap word captured on reset |
| strap_mod_off | input | 32 | Disabled-module mask captured on reset |
| bus_rdata | output | 32 | Registered read data |
| range_err | output | 1 | One-cycle flag for an out-of-range access |

## Verification
A read and a write can land in the same cycle. When they hit the same register, the ordering question becomes visible. The bench provokes this by issuing both strobes at one offset on a plain, a clear-on-one and a set-on-one register. It then expects the read data to show the old word and a follow-up read to show the updated word. Out-of-range reads and writes are also issued together, and the bench expects a single error pulse with no state change.

// File: rtl/sysctl_pkg.sv
package sysctl_pkg;

  typedef enum logic [1:0] {POL_RW, POL_RO, POL_W1C, POL_W1S} pol_e;

  localparam int NUM_REGS     = 82;
  localparam int IDX_CHIP_ID  = 0;
  localparam int IDX_STRAPS   = 1;
  localparam int IDX_IRQ_STAT = 16;
  localparam int IDX_RST_CAUS = 27;
  localparam int IDX_RST_LOCK = 28;
  localparam int IDX_MOD_OFF  = 31;
  localparam int IDX_MEM_CFG  = 39;
  localparam int IDX_CP_STAT  = 53;

  function automatic pol_e policy_of(input int idx);
    case (idx)
      IDX_CHIP_ID, IDX_STRAPS, IDX_IRQ_STAT: return POL_RO;
      IDX_RST_CAUS, IDX_CP_STAT:             return POL_W1C;
      IDX_RST_LOCK, IDX_MOD_OFF:             return POL_W1S;
      default:                               return POL_RW;
    endcase
  endfunction

  function automatic logic [31:0] const_reset(input int idx);
    case (idx)
      0:       return 32'h04A9_2750;
      5:       return 32'h0000_FFFF;
      14:      return 32'h0000_0003;
      15:      return 32'h0000_035E;
      20:      return 32'h0000_004E;
      24:      return 32'h0008_0000;
      27:      return 32'h8000_0000;
      30:      return 32'h0000_00C0;
      38:      return 32'h5A00_F3CF;
      79:      return 32'h0000_0008;
      80, 81:  return 32'h0347_30E4;
      default: return 32'h0;
    endcase
  endfunction

  function automatic bit dram_ok(input int mb);
    bit ok = 1'b0;
    for (int k = 0; k < 5; k++) if ((128 << k) == mb) ok = 1'b1;
    return ok;
  endfunction

  function automatic logic [31:0] dram_code(input int mb);
    logic [31:0] c = '0;
    for (int k = 0; k < 5; k++) if ((128 << k) == mb) c = 32'(k);
    return c;
  endfunction

  function automatic logic [31:0] mem_cfg_reset(input int mb);
    return 32'h0000_1002 | (dram_code(mb) << 8);
  endfunction

endpackage

// File: rtl/sysctl_decode.sv
module sysctl_decode #(
  parameter int ADDR_W   = 12,
  parameter int NUM_REGS = 82,
  localparam int IDX_W   = ADDR_W - 2
) (
  input  logic [ADDR_W-1:0] offset,
  output logic [IDX_W-1:0]  idx,
  output logic              in_range
);
  assign idx      = offset[ADDR_W-1:2];
  assign in_range = (32'(idx) < NUM_REGS);
endmodule

// File: rtl/sysctl_cell.sv
module sysctl_cell
  import sysctl_pkg::*;
#(
  parameter pol_e POLICY = POL_RW,
  parameter int   WIDTH  = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] rst_val,
  input  logic             wr_hit,
  input  logic [WIDTH-1:0] wdata,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] nxt;

  always_comb begin
    case (POLICY)
      POL_RO:  nxt = q;
      POL_W1C: nxt = q & ~wdata;
      POL_W1S: nxt = q | wdata;
      default: nxt = wdata;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      q <= rst_val;
    else if (wr_hit) q <= nxt;
  end
endmodule

// File: rtl/sysctl_rdpath.sv
module sysctl_rdpath #(
  parameter int NUM_REGS = 82,
  parameter int IDX_W    = 10,
  parameter int WIDTH    = 32
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           rd_en,
  input  logic                           oob_any,
  input  logic [IDX_W-1:0]               idx,
  input  logic [NUM_REGS-1:0][WIDTH-1:0] regs,
  output logic [WIDTH-1:0]               rdata,
  output logic                           range_err
);
  logic [WIDTH-1:0] word;

  always_comb begin
    word = '0;
    for (int i = 0; i < NUM_REGS; i++)
      if (idx == IDX_W'(i)) word = regs[i];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rdata     <= '0;
      range_err <= 1'b0;
    end else begin
      if (rd_en) rdata <= word;
      range_err <= oob_any;
    end
  end
endmodule

// File: rtl/sysctl_regbank.sv
module sysctl_regbank
  import sysctl_pkg::*;
#(
  parameter int DRAM_MB = 512,
  parameter int ADDR_W  = 12,
  parameter int DATA_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_off,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic [DATA_W-1:0] strap_boot,
  input  logic [DATA_W-1:0] strap_mod_off,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              range_err
);
  localparam int IDX_W = ADDR_W - 2;

  if (!dram_ok(DRAM_MB)) begin : g_bad_dram
    $error("DRAM_MB must be a power of two in 128..2048");
  end

  logic [IDX_W-1:0]               idx;
  logic                           in_range;
  logic                           rd_oob;
  logic                           wr_oob;
  logic [NUM_REGS-1:0][DATA_W-1:0] reg_q;

  sysctl_decode #(.ADDR_W(ADDR_W), .NUM_REGS(NUM_REGS)) u_dec (
    .offset(bus_off), .idx(idx), .in_range(in_range)
  );

  assign rd_oob = bus_rd & ~in_range;
  assign wr_oob = bus_wr & ~in_range;

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
    logic [DATA_W-1:0] rv;
    logic              hit;
    if (i == IDX_STRAPS) begin : g_rs
      assign rv = strap_boot;
    end else if (i == IDX_MOD_OFF) begin : g_rm
      assign rv = strap_mod_off;
    end else if (i == IDX_MEM_CFG) begin : g_rd
      assign rv = DATA_W'(mem_cfg_reset(DRAM_MB));
    end else begin : g_rc
      assign rv = DATA_W'(const_reset(i));
    end
    assign hit = bus_wr & in_range & (idx == IDX_W'(i));
    sysctl_cell #(.POLICY(policy_of(i)), .WIDTH(DATA_W)) u_cell (
      .clk(clk), .rst_n(rst_n), .rst_val(rv), .wr_hit(hit),
      .wdata(bus_wdata), .q(reg_q[i])
    );
  end

  sysctl_rdpath #(.NUM_REGS(NUM_REGS), .IDX_W(IDX_W), .WIDTH(DATA_W)) u_rd (
    .clk(clk), .rst_n(rst_n), .rd_en(bus_rd), .oob_any(rd_oob | wr_oob),
    .idx(idx), .regs(reg_q), .rdata(bus_rdata), .range_err(range_err)
  );
endmodule

// File: rtl/sysctl_checker.sv
module sysctl_checker #(
  parameter int NUM_REGS = 82,
  parameter int DATA_W   = 32
) (
  input logic                            clk,
  input logic                            rst_n,
  input logic                            rd_oob,
  input logic                            wr_oob,
  input logic                            range_err,
  input logic [DATA_W-1:0]               bus_rdata,
  input logic [NUM_REGS-1:0][DATA_W-1:0] reg_q
);
  AST_OOB_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    rd_oob |=> (bus_rdata == '0));                                            // R2
  AST_OOB_WRITE_INERT: assert property (@(posedge clk) disable iff (!rst_n)
    wr_oob |=> $stable(reg_q));                                               // R3
  AST_ERR_RAISE: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_oob || wr_oob) |=> range_err);                                        // R4
  AST_ERR_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_oob || wr_oob) |=> !range_err);                                      // R4
  AST_RO_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ($stable(reg_q[0]) && $stable(reg_q[1]) && $stable(reg_q[16]))); // R5
  AST_W1C_NO_SET: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (((reg_q[27] & ~$past(reg_q[27])) == '0) &&
              ((reg_q[53] & ~$past(reg_q[53])) == '0)));                      // R6
  AST_W1S_NO_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (((reg_q[28] & $past(reg_q[28])) == $past(reg_q[28])) &&
              ((reg_q[31] & $past(reg_q[31])) == $past(reg_q[31]))));         // R7
endmodule

bind sysctl_regbank sysctl_checker #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .rd_oob(rd_oob), .wr_oob(wr_oob),
  .range_err(range_err), .bus_rdata(bus_rdata), .reg_q(reg_q)
);

// File: tb/sysctl_regbank_bench.sv
module sysctl_regbank_bench;
  localparam int DRAM_MB = 512;
  localparam int NREG    = 82;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [11:0] bus_off = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] strap_boot = 32'hA5A5_0101;
  logic [31:0] strap_mod_off = 32'h0000_0F00;
  logic [31:0] bus_rdata;
  logic        range_err;

  int checks = 0, fails = 0;
  bit done = 0;
  logic [31:0] model [NREG];
  logic [31:0] exp_rd = '0;
  logic        exp_err = 1'b0;

  always #10 clk = ~clk;

  sysctl_regbank #(.DRAM_MB(DRAM_MB)) u_sysctl_regbank (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_off(bus_off), .bus_wdata(bus_wdata), .strap_boot(strap_boot),
    .strap_mod_off(strap_mod_off), .bus_rdata(bus_rdata), .range_err(range_err)
  );

  function automatic logic [31:0] ref_reset(input int boff);
    case (boff)
      'h000: return 32'h04A9_2750;
      'h004: return strap_boot;
      'h014: return 32'h0000_FFFF;
      'h038: return 32'h0000_0003;
      'h03C: return 32'h0000_035E;
      'h050: return 32'h0000_004E;
      'h060: return 32'h0008_0000;
      'h06C: return 32'h8000_0000;
      'h078: return 32'h0000_00C0;
      'h07C: return strap_mod_off;
      'h098: return 32'h5A00_F3CF;
      'h09C: return 32'h0000_1002 + ($clog2(DRAM_MB / 128) * 256);
      'h13C: return 32'h0000_0008;
      'h140, 'h144: return 32'h0347_30E4;
      default: return 32'h0;
    endcase
  endfunction

  function automatic string req_of(input int boff);
    case (boff)
      'h004, 'h07C: return "R10";
      'h09C:        return "R11";
      default:      return "R9";
    endcase
  endfunction

  function automatic string wreq_of(input int boff);
    case (boff)
      'h000, 'h004, 'h040: return "R5";
      'h06C, 'h0D4:        return "R6";
      'h070, 'h07C:        return "R7";
      default:             return "R8";
    endcase
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  // one bus cycle: drive at negedge, update the model at posedge, compare 1 ns later
  task automatic cyc(input bit w, input bit r, input int boff, input logic [31:0] d,
                     input string req);
    int i;
    @(negedge clk);
    bus_wr = w; bus_rd = r; bus_off = 12'(boff); bus_wdata = d;
    @(posedge clk);
    i = boff / 4;
    if (r) exp_rd = (i < NREG) ? model[i] : 32'h0;       // R12: value before write
    exp_err = (w || r) && (i >= NREG);
    if (w && i < NREG) begin
      case (boff)
        'h000, 'h004, 'h040: ;
        'h06C, 'h0D4: model[i] = model[i] & ~d;
        'h070, 'h07C: model[i] = model[i] | d;
        default:      model[i] = d;
      endcase
    end
    #1;
    check(req, bus_rdata, exp_rd);
    check({req, " R4 flag"}, {31'b0, range_err}, {31'b0, exp_err});
    @(negedge clk);
    bus_wr = 0; bus_rd = 0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0; bus_wr = 0; bus_rd = 0;
    repeat (2) @(posedge clk);
    for (int k = 0; k < NREG; k++) model[k] = ref_reset(k * 4);
    exp_rd = 0; exp_err = 0;
    #1;
    check("R13 rdata in reset", bus_rdata, 32'h0);
    check("R13 flag in reset", {31'b0, range_err}, 32'h0);
    @(negedge clk);
    rst_n = 1;
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    do_reset();
    // R9 R10 R11 reset image
    for (int k = 0; k < NREG; k++) cyc(0, 1, k * 4, 0, req_of(k * 4));
    // R1 hold without strobe
    cyc(0, 0, 'h000, 0, "R1 hold");
    // R5 R6 R7 R8 full-ones then all-zeros patterns
    for (int k = 0; k < NREG; k++) begin
      cyc(1, 0, k * 4, 32'hFFFF_FFFF, wreq_of(k * 4));
      cyc(0, 1, k * 4, 0, wreq_of(k * 4));
    end
    for (int k = 0; k < NREG; k++) begin
      cyc(1, 0, k * 4, 32'h0, wreq_of(k * 4));
      cyc(0, 1, k * 4, 0, wreq_of(k * 4));
    end
    do_reset();
    // R6 partial clear, R7 partial set
    cyc(1, 0, 'h06C, 32'h0000_0001, "R6");
    cyc(0, 1, 'h06C, 0, "R6 untouched bit");
    cyc(1, 0, 'h070, 32'h0000_00F0, "R7");
    cyc(1, 0, 'h070, 32'h0000_000F, "R7");
    cyc(0, 1, 'h070, 0, "R7 accumulate");
    cyc(1, 0, 'h07C, 32'h0, "R7");
    cyc(0, 1, 'h07C, 0, "R7 zero write");
    cyc(1, 0, 'h0D4, 32'h1234_5678, "R6");
    cyc(0, 1, 'h0D4, 0, "R6 zero stays");
    // R12 read and write together
    cyc(1, 0, 'h010, 32'hCAFE_0001, "R8");
    cyc(1, 1, 'h010, 32'hBEEF_0002, "R12 plain");
    cyc(0, 1, 'h010, 0, "R12 after");
    cyc(1, 1, 'h06C, 32'h8000_0000, "R12 clear-on-one");
    cyc(0, 1, 'h06C, 0, "R12 after");
    cyc(1, 1, 'h070, 32'h0001_0000, "R12 set-on-one");
    cyc(0, 1, 'h070, 0, "R12 after");
    // R2 R3 R4 out of range
    cyc(0, 1, 'h148, 0, "R2");
    cyc(0, 1, 'hFFC, 0, "R2");
    cyc(0, 0, 'hFFC, 0, "R4 drop");
    cyc(1, 0, 'h148, 32'hFFFF_FFFF, "R3");
    cyc(1, 1, 'hFFC, 32'h5555_5555, "R3 R2 both");
    for (int k = 0; k < NREG; k++) cyc(0, 1, k * 4, 0, "R3 image");
    // R10 reload with new straps, R7 set-on-one restored
    strap_boot = 32'h0BAD_F00D;
    strap_mod_off = 32'h8000_0001;
    do_reset();
    cyc(0, 1, 'h004, 0, "R10 boot");
    cyc(0, 1, 'h07C, 0, "R10 mask");
    cyc(0, 1, 'h070, 0, "R9 lock cleared");
    cyc(0, 1, 'h09C, 0, "R11");
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule